// File: doc/BRIEF.md
# Coprocessor register access decoder

This block sits between a processor's coprocessor instruction path and the register bank of a trace unit. For every coprocessor move-to or move-from instruction it receives the coprocessor number, the opcode1, CRn, CRm and opcode2 fields, a read/write flag, the processor mode, a debug-halted flag and the write data. It decides whether the instruction belongs to the trace unit. If it does, the block checks privilege and either raises an undefined-instruction or unpredictable indication, or turns the instruction into one access on a simple bank port.

The 10-bit register index is built from three instruction fields. A per-index implemented mask selects which indices reach the bank. Indices not marked in the mask read as zero and drop writes. The two lock indices always read as zero here, so no unlock sequence is needed on this path. The identification index returns a fixed nonzero word, so software can find out that the path exists. The decode verdict is registered. Read data comes back through a second stage that matches the bank's one-cycle read latency.

Top module: `cp_reg_access_dec`

## Requirements
- R1: Only instructions with coprocessor number 14 and opcode1 equal to 1 are claimed (handled_o=1). Any other instruction gives handled_o=0, undef_o=0 and unpred_o=0, and makes no bank request.
- R2: The bank index is {CRn[2:0], opcode2[2:0], CRm[3:0]}, with CRn in bits 9:7, opcode2 in bits 6:4 and CRm in bits 3:0.
- R3: A claimed instruction in User mode (mode_i = 5'b10000) with dbg_halt_i=0 gives undef_o=1. It makes no bank request and returns no read data, whatever its CRn.
- R4: With dbg_halt_i=1 a claimed instruction is treated as privileged even when mode_i is User.
- R5: A claimed, privileged instruction with CRn of 8 or more gives unpred_o=1 and undef_o=0, makes no bank request and returns no read data.
- R6: The default implemented mask covers indices 0x000 to 0x07F and 0x300 to 0x3FF. A privileged read of any other index returns rdata_o=0 with rdata_valid_o=1 and makes no bank request. A privileged write to such an index makes no bank request. Neither raises undef_o or unpred_o.
- R7: Reads of index 0x3EC or 0x3ED return zero without a bank request. Writes to them are not forwarded to the bank.
- R8: A read of index 0x079 (CRn=0, CRm=9, opcode2=7) returns ID_VALUE (default 32'h4D20_0A31) without a bank request. A write to that index is dropped.
- R9: resp_valid_o, handled_o, undef_o, unpred_o and the bank request appear one cycle after the instr_valid_i pulse. rdata_valid_o and rdata_o appear one cycle after that. Every privileged access with CRn below 8 that reads gives exactly one rdata_valid_o pulse.
- R10: A privileged write to an implemented, non-lock, non-identification index asserts bank_req_o and bank_we_o, with bank_wdata_o equal to wdata_i. Bank data read from that index afterwards appears on rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | One-cycle pulse for a coprocessor instruction |
| cp_num_i | input | 4 | Coprocessor number |
| opc1_i | input | 3 | Opcode1 field |
| crn_i | input | 4 | CRn field |
| crm_i | input | 4 | CRm field |
| opc2_i | input | 3 | Opcode2 field |
| is_read_i | input | 1 | 1 = move from coprocessor (read), 0 = write |
| mode_i | input | 5 | Processor mode, User = 5'b10000 |
| dbg_halt_i | input | 1 | Processor halted in debug state |
| wdata_i | input | 32 | Write data |
| resp_valid_o | output | 1 | Decode verdict valid |
| handled_o | output | 1 | Instruction claimed by this block |
| undef_o | output | 1 | Undefined-instruction exception |
| unpred_o | output | 1 | Unpredictable encoding |
| bank_req_o | output | 1 | Bank access strobe |
| bank_we_o | output | 1 | Bank write enable |
| bank_addr_o | output | 10 | Bank register index |
| bank_wdata_o | output | 32 | Bank write data |
| bank_rdata_i | input | 32 | Bank read data, one cycle after a read request |
| rdata_valid_o | output | 1 | Read result valid |
| rdata_o | output | 32 | Read result |

## Verification
The decode verdict and the bank request are due one cycle after instr_valid_i. Read data is due two cycles after, because the bank model in the bench answers one cycle after the request. The bench drives each instruction on a falling edge. It checks the verdict and the bank request on the falling edge after the first rising edge, and the read return on the falling edge after the second. Each instruction waits for its read return before the next one is driven, so no result is matched against the wrong instruction.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  localparam int CP_W   = 4;
  localparam int OPC_W  = 3;
  localparam int CRN_W  = 4;
  localparam int CRM_W  = 4;
  localparam int MODE_W = 5;
  localparam int IDX_W  = (CRN_W - 1) + OPC_W + CRM_W;
  localparam int NUM_REGS = 1 << IDX_W;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_BANK = 2'd1,
    SRC_ZERO = 2'd2,
    SRC_ID   = 2'd3
  } rsrc_e;

  typedef struct packed {
    logic             valid;
    logic             claimed;
    logic             undef;
    logic             unpred;
    logic             bank_rd;
    logic             bank_wr;
    rsrc_e            rsrc;
    logic [IDX_W-1:0] idx;
  } dec_t;

  // trace block 0x000-0x07F, management block 0x300-0x3FF
  function automatic logic [NUM_REGS-1:0] impl_mask_default();
    logic [NUM_REGS-1:0] m;
    for (int i = 0; i < NUM_REGS; i++) begin
      m[i] = (i < 'h080) || (i >= 'h300);
    end
    return m;
  endfunction
endpackage

// File: rtl/cpa_field_decode.sv
module cpa_field_decode
  import cpa_pkg::*;
#(
  parameter int unsigned         CP_NUM        = 14,
  parameter int unsigned         OPC1_SEL      = 1,
  parameter logic [MODE_W-1:0]   MODE_USER     = 5'b10000,
  parameter logic [IDX_W-1:0]    ID_IDX        = 10'h079,
  parameter logic [IDX_W-1:0]    LOCK_ACC_IDX  = 10'h3EC,
  parameter logic [IDX_W-1:0]    LOCK_STAT_IDX = 10'h3ED,
  parameter logic [NUM_REGS-1:0] IMPL_MASK     = impl_mask_default()
) (
  input  logic              valid_i,
  input  logic [CP_W-1:0]   cp_num_i,
  input  logic [OPC_W-1:0]  opc1_i,
  input  logic [CRN_W-1:0]  crn_i,
  input  logic [CRM_W-1:0]  crm_i,
  input  logic [OPC_W-1:0]  opc2_i,
  input  logic              is_read_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              dbg_halt_i,
  output dec_t              dec_o
);
  logic             claimed, priv, reserved, access;
  logic             is_lock, is_id, is_impl, bankable;
  logic [IDX_W-1:0] idx;

  assign idx      = {crn_i[CRN_W-2:0], opc2_i, crm_i};
  assign claimed  = valid_i && (cp_num_i == CP_W'(CP_NUM)) && (opc1_i == OPC_W'(OPC1_SEL));
  assign priv     = (mode_i != MODE_USER) || dbg_halt_i;
  assign reserved = crn_i[CRN_W-1];
  assign access   = claimed && priv && !reserved;

  assign is_lock  = (idx == LOCK_ACC_IDX) || (idx == LOCK_STAT_IDX);
  assign is_id    = (idx == ID_IDX);
  assign is_impl  = IMPL_MASK[idx];
  assign bankable = is_impl && !is_lock && !is_id;

  always_comb begin
    dec_o         = '0;
    dec_o.valid   = valid_i;
    dec_o.claimed = claimed;
    dec_o.undef   = claimed && !priv;
    dec_o.unpred  = claimed && priv && reserved;
    dec_o.idx     = idx;
    dec_o.bank_rd = access && is_read_i && bankable;
    dec_o.bank_wr = access && !is_read_i && bankable;
    dec_o.rsrc    = SRC_NONE;
    if (access && is_read_i) begin
      if (is_lock)       dec_o.rsrc = SRC_ZERO;
      else if (is_id)    dec_o.rsrc = SRC_ID;
      else if (is_impl)  dec_o.rsrc = SRC_BANK;
      else               dec_o.rsrc = SRC_ZERO;
    end
  end
endmodule

// File: rtl/cpa_req_stage.sv
module cpa_req_stage
  import cpa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  dec_t              dec_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              resp_valid_o,
  output logic              handled_o,
  output logic              undef_o,
  output logic              unpred_o,
  output logic              bank_req_o,
  output logic              bank_we_o,
  output logic [IDX_W-1:0]  bank_addr_o,
  output logic [DATA_W-1:0] bank_wdata_o,
  output rsrc_e             rsrc_o,
  output logic [IDX_W-1:0]  idx_o
);
  dec_t              dec_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q   <= '0;
      wdata_q <= '0;
    end else begin
      dec_q <= dec_i;
      if (dec_i.bank_wr) wdata_q <= wdata_i;
    end
  end

  assign resp_valid_o = dec_q.valid;
  assign handled_o    = dec_q.claimed;
  assign undef_o      = dec_q.undef;
  assign unpred_o     = dec_q.unpred;
  assign bank_req_o   = dec_q.bank_rd || dec_q.bank_wr;
  assign bank_we_o    = dec_q.bank_wr;
  assign bank_addr_o  = bank_req_o ? dec_q.idx : '0;
  assign bank_wdata_o = dec_q.bank_wr ? wdata_q : '0;
  assign rsrc_o       = dec_q.rsrc;
  assign idx_o        = dec_q.idx;

  assert_resp_timing_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i.valid |=> resp_valid_o);
  assert_one_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !(undef_o && unpred_o));
  assert_fault_no_bank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (undef_o || unpred_o) |-> (!bank_req_o && rsrc_o == SRC_NONE));
  assert_unclaimed_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !handled_o) |-> (!undef_o && !unpred_o && !bank_req_o));
endmodule

// File: rtl/cpa_read_return.sv
module cpa_read_return
  import cpa_pkg::*;
#(
  parameter int                DATA_W        = 32,
  parameter logic [DATA_W-1:0] ID_VALUE      = 32'h4D20_0A31,
  parameter logic [IDX_W-1:0]  LOCK_ACC_IDX  = 10'h3EC,
  parameter logic [IDX_W-1:0]  LOCK_STAT_IDX = 10'h3ED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rsrc_e             rsrc_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              bank_req_i,
  input  logic              bank_we_i,
  input  logic [DATA_W-1:0] bank_rdata_i,
  output logic              rdata_valid_o,
  output logic [DATA_W-1:0] rdata_o
);
  rsrc_e            rsrc_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsrc_q <= SRC_NONE;
      idx_q  <= '0;
    end else begin
      rsrc_q <= rsrc_i;
      idx_q  <= idx_i;
    end
  end

  assign rdata_valid_o = (rsrc_q != SRC_NONE);

  always_comb begin
    unique case (rsrc_q)
      SRC_BANK: rdata_o = bank_rdata_i;
      SRC_ID:   rdata_o = ID_VALUE;
      default:  rdata_o = '0;
    endcase
  end

  assert_read_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_req_i && !bank_we_i) |=> rdata_valid_o);
  assert_lock_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_valid_o && (idx_q == LOCK_ACC_IDX || idx_q == LOCK_STAT_IDX)) |-> (rdata_o == '0));
  assert_id_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsrc_q == SRC_ID) |-> (rdata_o != '0));
endmodule

// File: rtl/cp_reg_access_dec.sv
module cp_reg_access_dec
  import cpa_pkg::*;
#(
  parameter int unsigned         DATA_W        = 32,
  parameter int unsigned         CP_NUM        = 14,
  parameter int unsigned         OPC1_SEL      = 1,
  parameter logic [MODE_W-1:0]   MODE_USER     = 5'b10000,
  parameter logic [IDX_W-1:0]    ID_IDX        = 10'h079,
  parameter logic [DATA_W-1:0]   ID_VALUE      = 32'h4D20_0A31,
  parameter logic [IDX_W-1:0]    LOCK_ACC_IDX  = 10'h3EC,
  parameter logic [IDX_W-1:0]    LOCK_STAT_IDX = 10'h3ED,
  parameter logic [NUM_REGS-1:0] IMPL_MASK     = impl_mask_default()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [3:0]        cp_num_i,
  input  logic [2:0]        opc1_i,
  input  logic [3:0]        crn_i,
  input  logic [3:0]        crm_i,
  input  logic [2:0]        opc2_i,
  input  logic              is_read_i,
  input  logic [4:0]        mode_i,
  input  logic              dbg_halt_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              resp_valid_o,
  output logic              handled_o,
  output logic              undef_o,
  output logic              unpred_o,
  output logic              bank_req_o,
  output logic              bank_we_o,
  output logic [9:0]        bank_addr_o,
  output logic [DATA_W-1:0] bank_wdata_o,
  input  logic [DATA_W-1:0] bank_rdata_i,
  output logic              rdata_valid_o,
  output logic [DATA_W-1:0] rdata_o
);
  dec_t             dec;
  rsrc_e            rsrc_s1;
  logic [IDX_W-1:0] idx_s1;

  cpa_field_decode #(
    .CP_NUM(CP_NUM), .OPC1_SEL(OPC1_SEL), .MODE_USER(MODE_USER), .ID_IDX(ID_IDX),
    .LOCK_ACC_IDX(LOCK_ACC_IDX), .LOCK_STAT_IDX(LOCK_STAT_IDX), .IMPL_MASK(IMPL_MASK)
  ) u_decode (
    .valid_i(instr_valid_i), .cp_num_i(cp_num_i), .opc1_i(opc1_i), .crn_i(crn_i),
    .crm_i(crm_i), .opc2_i(opc2_i), .is_read_i(is_read_i), .mode_i(mode_i),
    .dbg_halt_i(dbg_halt_i), .dec_o(dec)
  );

  cpa_req_stage #(.DATA_W(DATA_W)) u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .dec_i(dec), .wdata_i(wdata_i),
    .resp_valid_o(resp_valid_o), .handled_o(handled_o), .undef_o(undef_o),
    .unpred_o(unpred_o), .bank_req_o(bank_req_o), .bank_we_o(bank_we_o),
    .bank_addr_o(bank_addr_o), .bank_wdata_o(bank_wdata_o),
    .rsrc_o(rsrc_s1), .idx_o(idx_s1)
  );

  cpa_read_return #(
    .DATA_W(DATA_W), .ID_VALUE(ID_VALUE),
    .LOCK_ACC_IDX(LOCK_ACC_IDX), .LOCK_STAT_IDX(LOCK_STAT_IDX)
  ) u_ret (
    .clk_i(clk_i), .rst_ni(rst_ni), .rsrc_i(rsrc_s1), .idx_i(idx_s1),
    .bank_req_i(bank_req_o), .bank_we_i(bank_we_o), .bank_rdata_i(bank_rdata_i),
    .rdata_valid_o(rdata_valid_o), .rdata_o(rdata_o)
  );

  assert_index_map_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && cp_num_i == 4'd14 && opc1_i == 3'd1 && !crn_i[3] &&
     (mode_i != MODE_USER || dbg_halt_i)) |=>
    (!bank_req_o || bank_addr_o == $past({crn_i[2:0], opc2_i, crm_i})));
  assert_write_data_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_req_o && bank_we_o) |-> (bank_wdata_o == $past(wdata_i)));
endmodule

// File: tb/cp_reg_access_dec_tb_top.sv
module cp_reg_access_dec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID_EXP = 32'h4D20_0A31;
  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_SVC = 5'b10011;

  typedef struct packed {
    logic [3:0] cp;
    logic [2:0] o1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] o2;
    logic       rd;
    logic [4:0] mode;
    logic       halt;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd14, 3'd1, 4'd0, 4'd9,  3'd7, 1'b1, M_SVC, 1'b0},  // ID
    '{4'd14, 3'd1, 4'd1, 4'd2,  3'd3, 1'b1, M_SVC, 1'b0},  // 0x0B2 unimpl
    '{4'd14, 3'd1, 4'd0, 4'd5,  3'd2, 1'b1, M_SVC, 1'b0},  // 0x025 bank
    '{4'd14, 3'd1, 4'd7, 4'd12, 3'd6, 1'b1, M_SVC, 1'b0},  // 0x3EC lock
    '{4'd14, 3'd1, 4'd7, 4'd13, 3'd6, 1'b1, M_SVC, 1'b0},  // 0x3ED lock
    '{4'd14, 3'd1, 4'd7, 4'd0,  3'd0, 1'b1, M_SVC, 1'b0},  // 0x380 bank
    '{4'd14, 3'd1, 4'd0, 4'd5,  3'd2, 1'b1, M_USR, 1'b0},  // user undef
    '{4'd14, 3'd1, 4'd0, 4'd5,  3'd2, 1'b1, M_USR, 1'b1},  // halted override
    '{4'd14, 3'd1, 4'd8, 4'd1,  3'd0, 1'b1, M_SVC, 1'b0},  // CRn 8 unpred
    '{4'd14, 3'd1, 4'd9, 4'd1,  3'd0, 1'b1, M_USR, 1'b0},  // CRn 9 user
    '{4'd15, 3'd1, 4'd0, 4'd5,  3'd2, 1'b1, M_SVC, 1'b0},  // other cp
    '{4'd14, 3'd0, 4'd0, 4'd5,  3'd2, 1'b1, M_SVC, 1'b0},  // opc1 0
    '{4'd14, 3'd2, 4'd0, 4'd5,  3'd2, 1'b1, M_USR, 1'b0}   // opc1 2 user
  };

  logic        clk, rst_n;
  logic        instr_valid, is_read, dbg_halt;
  logic [3:0]  cp_num, crn, crm;
  logic [2:0]  opc1, opc2;
  logic [4:0]  mode;
  logic [31:0] wdata;
  logic        resp_valid, handled, undef, unpred, bank_req, bank_we, rdata_valid;
  logic [9:0]  bank_addr;
  logic [31:0] bank_wdata, bank_rdata, rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] mem [1024];

  cp_reg_access_dec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .cp_num_i(cp_num),
    .opc1_i(opc1), .crn_i(crn), .crm_i(crm), .opc2_i(opc2), .is_read_i(is_read),
    .mode_i(mode), .dbg_halt_i(dbg_halt), .wdata_i(wdata),
    .resp_valid_o(resp_valid), .handled_o(handled), .undef_o(undef), .unpred_o(unpred),
    .bank_req_o(bank_req), .bank_we_o(bank_we), .bank_addr_o(bank_addr),
    .bank_wdata_o(bank_wdata), .bank_rdata_i(bank_rdata),
    .rdata_valid_o(rdata_valid), .rdata_o(rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] pat(input logic [9:0] i);
    return 32'hC0DE_0000 | {22'd0, i};
  endfunction

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = pat(10'(i));
  end

  // bank model: one-cycle read latency
  always @(posedge clk) begin
    if (bank_req) begin
      if (bank_we) mem[bank_addr] <= bank_wdata;
      else         bank_rdata     <= mem[bank_addr];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
  endtask

  // run one instruction, check verdict at +1 cycle and read return at +2
  task automatic run(input vec_t v, input logic [31:0] wd, input string tag,
                     input bit e_h, input bit e_u, input bit e_p,
                     input bit e_br, input bit e_bw, input logic [9:0] e_addr,
                     input bit e_rv, input logic [31:0] e_rd);
    @(negedge clk);
    instr_valid = 1'b1; cp_num = v.cp; opc1 = v.o1; crn = v.crn; crm = v.crm;
    opc2 = v.o2; is_read = v.rd; mode = v.mode; dbg_halt = v.halt; wdata = wd;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(resp_valid == 1'b1, {tag, " R9 resp_valid"}, 64'(resp_valid), 64'd1);
    chk({handled, undef, unpred} == {e_h, e_u, e_p}, {tag, " verdict h/u/p"},
        64'({handled, undef, unpred}), 64'({e_h, e_u, e_p}));
    chk({bank_req, bank_we} == {e_br, e_bw}, {tag, " bank req/we"},
        64'({bank_req, bank_we}), 64'({e_br, e_bw}));
    if (e_br) chk(bank_addr == e_addr, {tag, " R2 bank_addr"}, 64'(bank_addr), 64'(e_addr));
    if (e_bw) chk(bank_wdata == wd, {tag, " R10 bank_wdata"}, 64'(bank_wdata), 64'(wd));
    @(negedge clk);
    chk(rdata_valid == e_rv, {tag, " R9 rdata_valid"}, 64'(rdata_valid), 64'(e_rv));
    if (e_rv) chk(rdata == e_rd, {tag, " rdata"}, 64'(rdata), 64'(e_rd));
    chk(resp_valid == 1'b0, {tag, " R9 resp one-shot"}, 64'(resp_valid), 64'd0);
  endtask

  // expectation from the requirements
  task automatic run_model(input vec_t v, input logic [31:0] wd, input string tag);
    bit h, pr, u, p, acc, lock, idr, impl, bankable, rv;
    logic [9:0] idx;
    logic [31:0] rd;
    h    = (v.cp == 4'd14) && (v.o1 == 3'd1);                 // R1
    pr   = (v.mode != M_USR) || v.halt;                       // R3 R4
    u    = h && !pr;
    p    = h && pr && (v.crn >= 4'd8);                        // R5
    acc  = h && pr && (v.crn < 4'd8);
    idx  = {v.crn[2:0], v.o2, v.crm};                         // R2
    lock = (idx == 10'h3EC) || (idx == 10'h3ED);              // R7
    idr  = (idx == 10'h079);                                  // R8
    impl = (idx < 10'h080) || (idx >= 10'h300);               // R6
    bankable = impl && !lock && !idr;
    rv   = acc && v.rd;
    rd   = !rv ? 32'd0 : lock ? 32'd0 : idr ? ID_EXP : impl ? mem[idx] : 32'd0;
    run(v, wd, tag, h, u, p, acc && bankable, acc && !v.rd && bankable, idx, rv, rd);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    vec_t w;
    rst_n = 1'b0; instr_valid = 1'b0; cp_num = '0; opc1 = '0; crn = '0; crm = '0;
    opc2 = '0; is_read = 1'b0; mode = M_SVC; dbg_halt = 1'b0; wdata = '0;
    bank_rdata = '0;
    repeat (3) @(negedge clk);
    // reset state
    chk({resp_valid, handled, undef, unpred, bank_req, rdata_valid} == 6'd0,
        "R9 reset outputs idle",
        64'({resp_valid, handled, undef, unpred, bank_req, rdata_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({resp_valid, bank_req, rdata_valid} == 3'd0, "R9 idle after reset",
        64'({resp_valid, bank_req, rdata_valid}), 64'd0);

    for (int i = 0; i < NV; i++) run_model(VECS[i], 32'd0, $sformatf("vec%0d R1 R3 R4 R5 R6 R7 R8", i));

    // R10 write then read back
    w = '{4'd14, 3'd1, 4'd0, 4'd5, 3'd2, 1'b0, M_SVC, 1'b0};
    run(w, 32'h1234_5678, "R10 write 0x025", 1, 0, 0, 1, 1, 10'h025, 0, 32'd0);
    w.rd = 1'b1;
    run(w, 32'd0, "R10 readback 0x025", 1, 0, 0, 1, 0, 10'h025, 1, 32'h1234_5678);
    // R7 lock write dropped, still reads zero
    w = '{4'd14, 3'd1, 4'd7, 4'd12, 3'd6, 1'b0, M_SVC, 1'b0};
    run(w, 32'hC5AC_CE55, "R7 lock write", 1, 0, 0, 0, 0, 10'h3EC, 0, 32'd0);
    chk(mem[10'h3EC] == pat(10'h3EC), "R7 lock bank untouched", 64'(mem[10'h3EC]), 64'(pat(10'h3EC)));
    w.rd = 1'b1;
    run(w, 32'd0, "R7 lock read after write", 1, 0, 0, 0, 0, 10'h3EC, 1, 32'd0);
    // R8 ID write dropped, ID read unchanged
    w = '{4'd14, 3'd1, 4'd0, 4'd9, 3'd7, 1'b0, M_SVC, 1'b0};
    run(w, 32'hFFFF_FFFF, "R8 ID write", 1, 0, 0, 0, 0, 10'h079, 0, 32'd0);
    w.rd = 1'b1;
    run(w, 32'd0, "R8 ID read after write", 1, 0, 0, 0, 0, 10'h079, 1, ID_EXP);
    // R6 unimplemented write dropped
    w = '{4'd14, 3'd1, 4'd1, 4'd2, 3'd3, 1'b0, M_SVC, 1'b0};
    run(w, 32'hDEAD_BEEF, "R6 unimpl write", 1, 0, 0, 0, 0, 10'h0B2, 0, 32'd0);
    chk(mem[10'h0B2] == pat(10'h0B2), "R6 unimpl bank untouched", 64'(mem[10'h0B2]), 64'(pat(10'h0B2)));
    // R3 user write: undef, bank untouched
    w = '{4'd14, 3'd1, 4'd7, 4'd0, 3'd0, 1'b0, M_USR, 1'b0};
    run(w, 32'hBAD0_0001, "R3 user write", 1, 1, 0, 0, 0, 10'h380, 0, 32'd0);
    chk(mem[10'h380] == pat(10'h380), "R3 user write bank untouched", 64'(mem[10'h380]), 64'(pat(10'h380)));
    // R4 halted user write goes through
    w.halt = 1'b1;
    run(w, 32'h0BAD_F00D, "R4 halted write", 1, 0, 0, 1, 1, 10'h380, 0, 32'd0);
    w.rd = 1'b1;
    run(w, 32'd0, "R4 halted readback", 1, 0, 0, 1, 0, 10'h380, 1, 32'h0BAD_F00D);

    report();
    $finish;
  end
endmodule